// File: doc/BRIEF.md
# Stop/Go Majority-Clocked Keystream Generator

This block turns a 64-bit session key and a 22-bit frame number into a burst of keystream bits. It holds three maximal-length shift registers of 19, 22 and 23 bits. After a start strobe it clears all three registers. It then folds the key bits and the frame bits into them while every register steps on every cycle. Next it runs a warm-up phase whose output is thrown away. Finally it presents 228 keystream bits, one at a time, to a downstream consumer over a valid/ready handshake.

During warm-up and output, the registers do not all step on every cycle. Each register has one clocking-tap bit. A register shifts only when its tap bit matches the majority vote of the three tap bits, so on any cycle either two or all three registers shift. The keystream is split into two equal halves of 114 bits each. A direction flag marks which half the current bit belongs to. A one-cycle done pulse closes the burst.

Top module: `ks_gen`

## Requirements
- R1: After reset, `ks_valid`, `ks_dir`, `done` and `ks_bit` are all 0.
- R2: A start accepted in the idle state makes `ks_valid` rise exactly 187 clock edges later: 1 clear cycle, 86 load cycles and 100 warm-up cycles.
- R3: The accepted start clears all three registers to zero. The next 86 cycles step every register. The first 64 cycles take key bits 0 to 63 in that order, and the last 22 cycles take frame bits 0 to 21 in that order. On each of these cycles the input bit is XORed into every register's feedback value.
- R4: When a register steps, it shifts one place toward its MSB (bit 0 is the LSB), and the XOR of its feedback taps enters bit 0. The taps are: 19-bit register bits 18, 17, 16, 13; 22-bit register bits 21, 20; 23-bit register bits 22, 21, 20, 7.
- R5: During warm-up and on each output handshake, only the registers whose clocking bit equals the majority of the three clocking bits step. The clocking bits are bit 8, bit 10 and bit 10.
- R6: The warm-up runs 100 majority steps. Each presented keystream bit is the XOR of bits 18, 21 and 22 of the three registers taken after one further majority step. That step is committed when the bit is accepted.
- R7: Exactly 228 bits are delivered. `ks_dir` is 0 for bits 0 to 113 and 1 for bits 114 to 227, and it never falls within a burst.
- R8: While `ks_valid` is high and `ready` is low, the registers hold, and `ks_bit` and `ks_dir` stay unchanged.
- R9: One cycle after the 228th accepted bit, `done` is high for exactly one cycle while `ks_valid` is low.
- R10: A start pulse while a burst is in progress has no effect: the timing and the bit stream are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst (accepted only when idle) |
| key | input | 64 | Session key, sampled on an accepted start |
| iv | input | 22 | Frame number, sampled on an accepted start |
| ready | input | 1 | Downstream accepts the current bit |
| ks_bit | output | 1 | Current keystream bit |
| ks_valid | output | 1 | `ks_bit` is valid |
| ks_dir | output | 1 | Half of the burst: 0 first half, 1 second half |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The assertions check on every cycle the properties that hold locally:
- the load phase lasts exactly its fixed length,
- each register either holds or shifts by one place,
- registers and output are frozen while the consumer stalls,
- the direction flag never falls within a burst,
- done is a lone pulse with valid low,
- a start during warm-up does not disturb the sequence.

Other behaviours only show in the bench's scenarios against an independent model. These are the exact bit values (which depend on the tap positions, the majority rule and the order in which key and frame bits are folded in), the 187-cycle start latency, and the absence of any effect from starts injected mid-burst under random back-pressure.

// File: rtl/ks_gen.sv
module ks_gen #(
  parameter int L1 = 19,
  parameter int L2 = 22,
  parameter int L3 = 23,
  parameter logic [L1-1:0] T1 = 19'h72000,
  parameter logic [L2-1:0] T2 = 22'h300000,
  parameter logic [L3-1:0] T3 = 23'h700080,
  parameter int C1 = 8,
  parameter int C2 = 10,
  parameter int C3 = 10,
  parameter int KEY_W = 64,
  parameter int IV_W = 22,
  parameter int WARM = 100,
  parameter int BURST = 228
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key,
  input  logic [IV_W-1:0]  iv,
  input  logic             ready,
  output logic             ks_bit,
  output logic             ks_valid,
  output logic             ks_dir,
  output logic             done
);
  localparam int LD = KEY_W + IV_W;
  localparam int CW = $clog2(LD + WARM + BURST);
  localparam logic [CW-1:0] LAST_LD = CW'(LD - 1);
  localparam logic [CW-1:0] LAST_WU = CW'(WARM - 1);
  localparam logic [CW-1:0] LAST_KS = CW'(BURST - 1);
  localparam logic [CW-1:0] HALF    = CW'(BURST / 2);

  typedef enum logic [2:0] {IDLE, LOAD, WUP, OUTP, FIN} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [LD-1:0] seed;
  logic [L1-1:0] r1;
  logic [L2-1:0] r2;
  logic [L3-1:0] r3;

  wire fb1 = ^(r1 & T1);
  wire fb2 = ^(r2 & T2);
  wire fb3 = ^(r3 & T3);
  wire mj  = (r1[C1] & r2[C2]) | (r1[C1] & r3[C3]) | (r2[C2] & r3[C3]);
  wire e1  = r1[C1] == mj;
  wire e2  = r2[C2] == mj;
  wire e3  = r3[C3] == mj;
  wire lb  = seed[0];

  wire [L1-1:0] s1 = e1 ? {r1[L1-2:0], fb1} : r1;
  wire [L2-1:0] s2 = e2 ? {r2[L2-2:0], fb2} : r2;
  wire [L3-1:0] s3 = e3 ? {r3[L3-2:0], fb3} : r3;

  assign ks_bit   = s1[L1-1] ^ s2[L2-1] ^ s3[L3-1];
  assign ks_valid = st == OUTP;
  assign ks_dir   = ks_valid && (cnt >= HALF);
  assign done     = st == FIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      seed <= '0;
      r1   <= '0;
      r2   <= '0;
      r3   <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          r1   <= '0;
          r2   <= '0;
          r3   <= '0;
          seed <= {iv, key};
          cnt  <= '0;
          st   <= LOAD;
        end
        LOAD: begin
          r1   <= {r1[L1-2:0], fb1 ^ lb};
          r2   <= {r2[L2-2:0], fb2 ^ lb};
          r3   <= {r3[L3-2:0], fb3 ^ lb};
          seed <= seed >> 1;
          if (cnt == LAST_LD) begin
            cnt <= '0;
            st  <= WUP;
          end else cnt <= cnt + 1'b1;
        end
        WUP: begin
          r1 <= s1;
          r2 <= s2;
          r3 <= s3;
          if (cnt == LAST_WU) begin
            cnt <= '0;
            st  <= OUTP;
          end else cnt <= cnt + 1'b1;
        end
        OUTP: if (ready) begin
          r1 <= s1;
          r2 <= s2;
          r3 <= s3;
          if (cnt == LAST_KS) begin
            cnt <= '0;
            st  <= FIN;
          end else cnt <= cnt + 1'b1;
        end
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  // R3
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOAD) |=> ((st == WUP && $past(cnt) == LAST_LD) ||
                      (st == LOAD && cnt == $past(cnt) + 1'b1)));

  // R4
  shift_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WUP || st == OUTP) |=>
      ((r1 == $past(r1)) || (r1[L1-1:1] == $past(r1[L1-2:0]))) &&
      ((r2 == $past(r2)) || (r2[L2-1:1] == $past(r2[L2-2:0]))) &&
      ((r3 == $past(r3)) || (r3[L3-1:1] == $past(r3[L3-2:0]))));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ready) |=> ks_valid && $stable(r1) && $stable(r2) &&
                             $stable(r3) && $stable(ks_bit) && $stable(ks_dir));

  // R7
  dir_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && $past(ks_valid) && $past(ks_dir)) |-> ks_dir);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ks_valid ##1 !done);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WUP && start) |=> (st == WUP || st == OUTP));
endmodule

// File: tb/tb_ks_gen.sv
`timescale 1ns/1ps
module tb_ks_gen;
  logic clk = 1'b0;
  logic rst_n, start, ready;
  logic [63:0] key;
  logic [21:0] iv;
  logic ks_bit, ks_valid, ks_dir, done;
  int checks = 0;
  int errors = 0;
  logic [227:0] exp_ks;

  always #2.5 clk = ~clk;

  ks_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
    .ready(ready), .ks_bit(ks_bit), .ks_valid(ks_valid),
    .ks_dir(ks_dir), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic build(input logic [63:0] k, input logic [21:0] v);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] c;
    logic [85:0] sd;
    logic m;
    a = '0; b = '0; c = '0;
    sd = {v, k};
    for (int i = 0; i < 86; i++) begin
      a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13] ^ sd[i]};
      b = {b[20:0], b[21] ^ b[20] ^ sd[i]};
      c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7] ^ sd[i]};
    end
    for (int i = 0; i < 328; i++) begin
      m = maj3(a[8], b[10], c[10]);
      if (a[8] == m) a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
      if (b[10] == m) b = {b[20:0], b[21] ^ b[20]};
      if (c[10] == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
      if (i >= 100) exp_ks[i-100] = a[18] ^ b[21] ^ c[22];
    end
  endtask

  task automatic run_frame(input logic [63:0] k, input logic [21:0] v,
                           input bit rnd, input bit poke);
    int n;
    int idx;
    bit r;
    string tag;
    tag = poke ? "R6/R10" : "R6";
    build(k, v);
    @(negedge clk);
    key = k; iv = v; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < 186) begin
      @(negedge clk);
      n++;
      start = poke && (n == 100);
      if (n == 185) chk(!ks_valid, "R2 valid early", 64'(ks_valid), 64'd0);
    end
    chk(ks_valid, "R2 valid at 187", 64'(ks_valid), 64'd1);
    idx = 0;
    while (idx < 228) begin
      r = rnd ? 1'($urandom % 2) : 1'b1;
      ready = r;
      start = poke && (idx == 50);
      chk(ks_valid, "R7 valid in burst", 64'(ks_valid), 64'd1);
      chk(ks_bit == exp_ks[idx], tag, 64'(ks_bit), 64'(exp_ks[idx]));
      chk(ks_dir == (idx >= 114), "R7 dir", 64'(ks_dir), 64'(idx >= 114));
      if (!r) chk(!done, "R8 stall", 64'(done), 64'd0);
      @(negedge clk);
      if (r) idx++;
    end
    ready = 1'b0;
    start = 1'b0;
    chk(done && !ks_valid, "R9 done pulse", {ks_valid, done}, 64'd1);
    @(negedge clk);
    chk(!done && !ks_valid, "R9 done single", {ks_valid, done}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; ready = 1'b0; key = '0; iv = '0;
    repeat (3) @(negedge clk);
    chk(!ks_valid && !done && !ks_dir && !ks_bit, "R1 reset",
        {ks_valid, done, ks_dir, ks_bit}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ks_valid && !done, "R1 idle", {ks_valid, done}, 64'd0);
    // R3 all-zero inputs keep every register zero
    run_frame(64'd0, 22'd0, 1'b0, 1'b0);
    // R4 R5 dense inputs with back-pressure and busy starts
    run_frame({64{1'b1}}, {22{1'b1}}, 1'b1, 1'b1);
    // R3 single key bit: LSB first ordering
    run_frame(64'd1, 22'd0, 1'b0, 1'b0);
    run_frame(64'd0, 22'h200000, 1'b1, 1'b0);
    for (int f = 0; f < 4; f++)
      run_frame({$urandom, $urandom}, 22'($urandom), 1'b1, f[0]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule